// File: doc/BRIEF.md
# Remote DMA Byte-Port Engine

This block lets a host move bytes between its register window and a local buffer memory, one byte per access of a single data port. The host programs a 16-bit start address and a 16-bit byte count. It then writes a command byte that starts a remote read or a remote write. Each later access to the data port moves one byte at the current address, advances the address by one and lowers the remaining count. When the count runs out the engine goes idle and raises a sticky completion flag. The host clears that flag by writing a one to it.

The local address space is split in two. From a parameterised packet base (0x4000) upward, accesses reach the buffer memory. Below that base the engine serves a fixed 32-byte identification image, mirrored every 32 bytes. The image holds the station address and eight product bytes. The first copy ends in two 0x57 bytes. The second copy repeats the first fourteen bytes and ends in two 0x42 bytes. The host can read back the live current address at any time.

Top module: `rdma_port_engine`

## Requirements
- R1: After a synchronous active-low reset, `irq_done` is 0, the current address reads back as 0x0000, and the interrupt status offset reads 0x00.
- R2: Writes to offsets 0x8/0x9 set the start address (low/high byte) and writes to 0x0A/0x0B set the byte count (low/high byte). A command whose field in bits 5:3 is 001 (read) or 010 (write) copies the start address into the current address. Reads of 0x8/0x9 return the low/high byte of the current address.
- R3: In read mode, a read of the port at offset 0x10 returns, in `reg_rdata` one cycle later, the byte at the current address, and advances the address by one.
- R4: In write mode, a write to the port at an address at or above 0x4000 pulses `mem_we` for that cycle, with `mem_addr` equal to the current address and `mem_wdata` equal to the written byte, and advances the address by one.
- R5: In write mode, port writes to an address below 0x4000 do not pulse `mem_we`, and the address still advances.
- R6: Below 0x4000, address bits 4:0 select image byte i. For k = i mod 16: if k < 6 the byte is station byte k (bits 8k+7:8k of `STATION_ID`); if 6 ≤ k < 14 it is product byte k-6 of `PRODUCT_ID`; otherwise it is 0x57 when i < 16 and 0x42 when i ≥ 16.
- R7: Once the programmed count of port accesses is done, `irq_done` rises and the engine goes idle. In idle, a port read returns 0x00, a port write does not pulse `mem_we`, and neither moves the address.
- R8: Command code 100 stops a transfer at once, sets `irq_done` and leaves the address where it was.
- R9: `irq_done` appears as bit 6 of offset 0x7 and stays set until the host writes 0x7 with bit 6 set.
- R10: Command codes 000 and 011 leave the engine state unchanged. A read or write command with a byte count of zero completes at once: `irq_done` is set and the current address equals the start address.
- R11: A port access in the direction that does not match the running mode is ignored: no data moves and the address holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Host register write strobe |
| reg_rd | input | 1 | Host register read strobe |
| reg_addr | input | 5 | Host register offset |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data, registered, valid the cycle after `reg_rd` |
| irq_done | output | 1 | Sticky transfer-complete flag |
| mem_addr | output | 16 | Buffer memory address (live current address) |
| mem_we | output | 1 | Buffer memory write strobe |
| mem_wdata | output | 8 | Buffer memory write data |
| mem_rdata | input | 8 | Buffer memory read data, combinational from `mem_addr` |

## Verification
Register writes, commands and port accesses change the current address, the mode and `irq_done` at the clock edge that samples them, so the bench reads these back on the falling edge that follows that edge. Read data goes through one output register. The bench therefore holds `reg_rd` across one rising edge and samples `reg_rdata` on the next falling edge. `mem_we` and its address and data are combinational in the access cycle. They are taken by the bench's memory model at that rising edge, counted there, and checked afterwards by reading the model's contents and its write count.

// File: rtl/rdma_pkg.sv
// Shared definitions for the remote DMA byte-port engine.
// Assumes an 8-bit host data path and a 16-bit local address space.
package rdma_pkg;
    localparam int BYTE_W  = 8;
    localparam int LADDR_W = 16;
    localparam int OFF_W   = 5;

    // Command field position inside the command byte
    localparam int CMD_LSB = 3;
    localparam int CMD_W   = 3;

    // Completion flag position in the interrupt status byte
    localparam int DONE_BIT = 6;

    // Register offsets seen by the host
    localparam logic [OFF_W-1:0] OFF_CMD   = 5'h00;
    localparam logic [OFF_W-1:0] OFF_INT   = 5'h07;
    localparam logic [OFF_W-1:0] OFF_SA_LO = 5'h08;
    localparam logic [OFF_W-1:0] OFF_SA_HI = 5'h09;
    localparam logic [OFF_W-1:0] OFF_BC_LO = 5'h0A;
    localparam logic [OFF_W-1:0] OFF_BC_HI = 5'h0B;
    localparam logic [OFF_W-1:0] OFF_PORT  = 5'h10;

    typedef enum logic [CMD_W-1:0] {
        RCMD_NONE  = 3'b000,
        RCMD_READ  = 3'b001,
        RCMD_WRITE = 3'b010,
        RCMD_SEND  = 3'b011,
        RCMD_STOP  = 3'b100
    } rcmd_e;

    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_READ  = 2'd1,
        ENG_WRITE = 2'd2
    } eng_e;
endpackage

// File: rtl/rdma_ctrl.sv
// Transfer controller: holds the start address and byte count, and runs the
// current address, the remaining count and the completion flag.
// Assumes at most one host access per cycle.
module rdma_ctrl
    import rdma_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [BYTE_W-1:0]  wdata,
    input  logic               ld_sa_lo,
    input  logic               ld_sa_hi,
    input  logic               ld_bc_lo,
    input  logic               ld_bc_hi,
    input  logic               cmd_wr,
    input  logic [CMD_W-1:0]   cmd_code,
    input  logic               port_rd,
    input  logic               port_wr,
    input  logic               clr_done,
    output logic [LADDR_W-1:0] cur_addr,
    output eng_e               mode,
    output logic               step,
    output logic               done
);
    logic [LADDR_W-1:0] start_q;
    logic [LADDR_W-1:0] count_q;
    logic [LADDR_W-1:0] left_q;
    logic               go_cmd;
    logic               zero_go;
    logic               last_step;

    // A port access moves data only in the matching direction
    assign step      = (mode == ENG_READ  && port_rd) || (mode == ENG_WRITE && port_wr);
    assign go_cmd    = cmd_wr && (cmd_code == RCMD_READ || cmd_code == RCMD_WRITE);
    assign zero_go   = go_cmd && (count_q == '0);
    assign last_step = step && (left_q == LADDR_W'(1));

    // Programmed start address and byte count, loaded a byte at a time
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            count_q <= '0;
        end else begin
            if (ld_sa_lo) start_q[BYTE_W-1:0]       <= wdata;
            if (ld_sa_hi) start_q[LADDR_W-1:BYTE_W] <= wdata;
            if (ld_bc_lo) count_q[BYTE_W-1:0]       <= wdata;
            if (ld_bc_hi) count_q[LADDR_W-1:BYTE_W] <= wdata;
        end
    end

    // Engine mode, current address and remaining count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode     <= ENG_IDLE;
            cur_addr <= '0;
            left_q   <= '0;
        end else if (cmd_wr) begin
            case (cmd_code)
                RCMD_READ, RCMD_WRITE: begin
                    cur_addr <= start_q;
                    left_q   <= count_q;
                    if (count_q == '0)
                        mode <= ENG_IDLE;
                    else
                        mode <= (cmd_code == RCMD_READ) ? ENG_READ : ENG_WRITE;
                end
                RCMD_STOP: begin
                    mode   <= ENG_IDLE;
                    left_q <= '0;
                end
                default: ;
            endcase
        end else if (step) begin
            cur_addr <= cur_addr + LADDR_W'(1);
            left_q   <= left_q - LADDR_W'(1);
            if (left_q == LADDR_W'(1))
                mode <= ENG_IDLE;
        end
    end

    // Sticky completion flag: set on end, abort or empty start; cleared by host
    always_ff @(posedge clk) begin
        if (!rst_n)
            done <= 1'b0;
        else if (last_step || zero_go || (cmd_wr && cmd_code == RCMD_STOP))
            done <= 1'b1;
        else if (clr_done)
            done <= 1'b0;
    end
endmodule

// File: rtl/rdma_idprom.sv
// Identification image served below the packet base: 16 content bytes,
// the second copy differing only in its two trailing marker bytes.
// Purely combinational; assumes the caller passes address bits 4:0.
module rdma_idprom
    import rdma_pkg::*;
#(
    parameter logic [47:0] STATION_ID = 48'h0,
    parameter logic [63:0] PRODUCT_ID = 64'h0,
    parameter logic [7:0]  MARK_LO    = 8'h57,
    parameter logic [7:0]  MARK_HI    = 8'h42
) (
    input  logic [4:0]        idx,
    output logic [BYTE_W-1:0] val
);
    localparam int N_STA  = 6;
    localparam int N_BODY = 14;

    logic [BYTE_W-1:0] body [N_BODY];

    // Content table built from the station and product parameters
    for (genvar g = 0; g < N_BODY; g++) begin : g_body
        if (g < N_STA) begin : g_sta
            assign body[g] = STATION_ID[8*g +: 8];
        end else begin : g_prod
            assign body[g] = PRODUCT_ID[8*(g-N_STA) +: 8];
        end
    end

    // Bytes 14 and 15 of each copy are the copy's marker
    always_comb begin
        if (idx[3:0] >= 4'(N_BODY))
            val = idx[4] ? MARK_HI : MARK_LO;
        else
            val = body[idx[3:0]];
    end
endmodule

// File: rtl/rdma_rdmux.sv
// Host read-data selection: current address bytes, interrupt status, and the
// data port (image or buffer memory). Combinational; registered by the top.
module rdma_rdmux
    import rdma_pkg::*;
#(
    parameter logic [LADDR_W-1:0] PKT_BASE = 16'h4000
) (
    input  logic [OFF_W-1:0]   offset,
    input  logic               port_take,
    input  logic [LADDR_W-1:0] cur_addr,
    input  logic               done,
    input  logic [BYTE_W-1:0]  prom_byte,
    input  logic [BYTE_W-1:0]  mem_byte,
    output logic [BYTE_W-1:0]  rd_byte
);
    // Pick the byte for the addressed offset; idle port reads yield zero
    always_comb begin
        rd_byte = '0;
        case (offset)
            OFF_SA_LO: rd_byte = cur_addr[BYTE_W-1:0];
            OFF_SA_HI: rd_byte = cur_addr[LADDR_W-1:BYTE_W];
            OFF_INT:   rd_byte[DONE_BIT] = done;
            OFF_PORT:  if (port_take)
                           rd_byte = (cur_addr >= PKT_BASE) ? mem_byte : prom_byte;
            default:   rd_byte = '0;
        endcase
    end
endmodule

// File: rtl/rdma_port_engine.sv
// Top of the remote DMA byte-port engine. Decodes host register accesses,
// drives the buffer memory and registers host read data.
// Assumes reg_wr and reg_rd are never high together and that mem_rdata
// follows mem_addr within the same cycle.
module rdma_port_engine
    import rdma_pkg::*;
#(
    parameter logic [LADDR_W-1:0] PKT_BASE   = 16'h4000,
    parameter logic [47:0]        STATION_ID = 48'h0605_0403_0201,
    parameter logic [63:0]        PRODUCT_ID = 64'h1817_1615_1413_1211
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [OFF_W-1:0]   reg_addr,
    input  logic [BYTE_W-1:0]  reg_wdata,
    output logic [BYTE_W-1:0]  reg_rdata,
    output logic               irq_done,
    output logic [LADDR_W-1:0] mem_addr,
    output logic               mem_we,
    output logic [BYTE_W-1:0]  mem_wdata,
    input  logic [BYTE_W-1:0]  mem_rdata
);
    logic [LADDR_W-1:0] cur_addr;
    eng_e               mode;
    logic               step;
    logic               busy;
    logic [BYTE_W-1:0]  prom_byte;
    logic [BYTE_W-1:0]  rd_byte;
    logic               port_rd;
    logic               port_wr;

    assign port_rd = reg_rd && (reg_addr == OFF_PORT);
    assign port_wr = reg_wr && (reg_addr == OFF_PORT);
    assign busy    = (mode != ENG_IDLE);

    rdma_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wdata    (reg_wdata),
        .ld_sa_lo (reg_wr && reg_addr == OFF_SA_LO),
        .ld_sa_hi (reg_wr && reg_addr == OFF_SA_HI),
        .ld_bc_lo (reg_wr && reg_addr == OFF_BC_LO),
        .ld_bc_hi (reg_wr && reg_addr == OFF_BC_HI),
        .cmd_wr   (reg_wr && reg_addr == OFF_CMD),
        .cmd_code (reg_wdata[CMD_LSB +: CMD_W]),
        .port_rd  (port_rd),
        .port_wr  (port_wr),
        .clr_done (reg_wr && reg_addr == OFF_INT && reg_wdata[DONE_BIT]),
        .cur_addr (cur_addr),
        .mode     (mode),
        .step     (step),
        .done     (irq_done)
    );

    rdma_idprom #(
        .STATION_ID (STATION_ID),
        .PRODUCT_ID (PRODUCT_ID)
    ) u_prom (
        .idx (cur_addr[4:0]),
        .val (prom_byte)
    );

    rdma_rdmux #(
        .PKT_BASE (PKT_BASE)
    ) u_mux (
        .offset    (reg_addr),
        .port_take (step && mode == ENG_READ),
        .cur_addr  (cur_addr),
        .done      (irq_done),
        .prom_byte (prom_byte),
        .mem_byte  (mem_rdata),
        .rd_byte   (rd_byte)
    );

    // Buffer memory side: writes reach memory only in the packet region
    assign mem_addr  = cur_addr;
    assign mem_wdata = reg_wdata;
    assign mem_we    = step && (mode == ENG_WRITE) && (cur_addr >= PKT_BASE);

    // Host read data register, loaded on every register read
    always_ff @(posedge clk) begin
        if (!rst_n)
            reg_rdata <= '0;
        else if (reg_rd)
            reg_rdata <= rd_byte;
    end
endmodule

// Protocol checker for the byte-port engine; observes ports and the engine's
// busy/step signals.
module rdma_port_engine_chk
    import rdma_pkg::*;
#(
    parameter logic [LADDR_W-1:0] PKT_BASE = 16'h4000
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_wr,
    input logic [OFF_W-1:0]   reg_addr,
    input logic [BYTE_W-1:0]  reg_wdata,
    input logic               irq_done,
    input logic [LADDR_W-1:0] mem_addr,
    input logic               mem_we,
    input logic               busy,
    input logic               step
);
    AST_WE_PKT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_addr >= PKT_BASE); // R5

    AST_IDLE_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_we); // R7

    AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> mem_addr == $past(mem_addr) + 16'd1); // R3

    AST_IDLE_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(reg_wr && reg_addr == OFF_CMD)) |=> $stable(mem_addr)); // R7

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_done && !(reg_wr && reg_addr == OFF_INT && reg_wdata[DONE_BIT])) |=> irq_done); // R9

    AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFF_CMD && reg_wdata[CMD_LSB +: CMD_W] == RCMD_STOP)
        |=> (!busy && irq_done)); // R8
endmodule

bind rdma_port_engine rdma_port_engine_chk #(.PKT_BASE(PKT_BASE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .irq_done  (irq_done),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .busy      (busy),
    .step      (step)
);

// File: tb/test_rdma_port_engine.sv
module test_rdma_port_engine;
    localparam logic [47:0] STA  = 48'hA5B4_C3D2_E1F0;
    localparam logic [63:0] PROD = 64'h8877_6655_4433_2211;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        irq_done;
    logic [15:0] mem_addr;
    logic        mem_we;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;

    logic [7:0]  bmem [256];
    int          we_cnt = 0;
    int          n_chk = 0;
    int          n_err = 0;

    always #2.5 clk = ~clk;

    rdma_port_engine #(.STATION_ID(STA), .PRODUCT_ID(PROD)) i_rdma_port_engine (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_done(irq_done), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Buffer memory model: 256 bytes mirrored over the address space
    assign mem_rdata = bmem[mem_addr[7:0]];
    always @(posedge clk) begin
        if (mem_we) begin
            bmem[mem_addr[7:0]] <= mem_wdata;
            we_cnt = we_cnt + 1;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(posedge clk);
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic get_addr(output int v);
        logic [7:0] lo, hi;
        rd(5'h08, lo);
        rd(5'h09, hi);
        v = {hi, lo};
    endtask

    task automatic setup(input logic [15:0] sa, input logic [15:0] bc);
        wr(5'h08, sa[7:0]); wr(5'h09, sa[15:8]);
        wr(5'h0A, bc[7:0]); wr(5'h0B, bc[15:8]);
    endtask

    function automatic logic [7:0] prom_exp(input int i);
        int k = i % 16;
        if (k < 6)  return STA[8*k +: 8];
        if (k < 14) return PROD[8*(k-6) +: 8];
        return (i < 16) ? 8'h57 : 8'h42;
    endfunction

    task automatic t_reset();
        int v; logic [7:0] b;
        check("R1 irq", irq_done, 0);
        get_addr(v);
        check("R1 addr", v, 0);
        rd(5'h07, b);
        check("R1 status", b, 0);
    endtask

    task automatic t_prom_read();
        int v; logic [7:0] b; int bad = 0;
        setup(16'h0000, 16'd32);
        wr(5'h00, 8'h0A);                 // read command, code 001
        for (int i = 0; i < 32; i++) begin
            rd(5'h10, b);
            if (b != prom_exp(i)) begin
                bad++;
                check("R6 image byte", b, prom_exp(i));
            end
        end
        check("R6 image all", bad, 0);
        check("R7 irq after count", irq_done, 1);
        get_addr(v);
        check("R2 addr after read", v, 16'h0020);
        rd(5'h10, b);
        check("R7 idle read data", b, 0);
        get_addr(v);
        check("R7 idle addr hold", v, 16'h0020);
    endtask

    task automatic t_clear();
        logic [7:0] b;
        rd(5'h07, b);
        check("R9 status bit6", b, 8'h40);
        wr(5'h07, 8'h40);
        check("R9 irq cleared", irq_done, 0);
        rd(5'h07, b);
        check("R9 status clear", b, 0);
    endtask

    task automatic t_pkt_write();
        int v; int w0;
        wr(5'h07, 8'h40);
        w0 = we_cnt;
        setup(16'h4010, 16'd3);
        wr(5'h00, 8'h12);                 // write command, code 010
        get_addr(v);
        check("R2 start loaded", v, 16'h4010);
        wr(5'h10, 8'hC1); wr(5'h10, 8'hC2); wr(5'h10, 8'hC3);
        check("R4 mem 0x10", bmem[8'h10], 8'hC1);
        check("R4 mem 0x12", bmem[8'h12], 8'hC3);
        check("R4 write count", we_cnt - w0, 3);
        check("R7 irq write end", irq_done, 1);
        wr(5'h10, 8'hEE);
        check("R7 idle write ignored", we_cnt - w0, 3);
        get_addr(v);
        check("R7 addr after write", v, 16'h4013);
    endtask

    task automatic t_prom_write();
        int v; int w0;
        wr(5'h07, 8'h40);
        w0 = we_cnt;
        bmem[0] = 8'h00; bmem[1] = 8'h00; bmem[8'hFE] = 8'h00; bmem[8'hFF] = 8'h00;
        setup(16'h3FFE, 16'd4);
        wr(5'h00, 8'h12);
        wr(5'h10, 8'hA1); wr(5'h10, 8'hA2); wr(5'h10, 8'hA3); wr(5'h10, 8'hA4);
        check("R5 only packet writes", we_cnt - w0, 2);
        check("R5 mem 0xFE untouched", bmem[8'hFE], 0);
        check("R5 mem 0x00", bmem[0], 8'hA3);
        check("R5 mem 0x01", bmem[1], 8'hA4);
        get_addr(v);
        check("R5 addr advanced", v, 16'h4002);
    endtask

    task automatic t_pkt_read();
        int v; logic [7:0] b; int w0;
        wr(5'h07, 8'h40);
        bmem[8'h20] = 8'h5C; bmem[8'h21] = 8'h6D;
        setup(16'h4020, 16'd2);
        wr(5'h00, 8'h0A);
        rd(5'h10, b);
        check("R3 first byte", b, 8'h5C);
        w0 = we_cnt;
        wr(5'h10, 8'h99);                 // wrong direction
        check("R11 no write", we_cnt - w0, 0);
        get_addr(v);
        check("R11 addr hold", v, 16'h4021);
        check("R11 no completion", irq_done, 0);
        rd(5'h10, b);
        check("R3 second byte", b, 8'h6D);
        check("R7 irq read end", irq_done, 1);
    endtask

    task automatic t_abort();
        int v; logic [7:0] b;
        wr(5'h07, 8'h40);
        setup(16'h4040, 16'd10);
        wr(5'h00, 8'h0A);
        rd(5'h10, b); rd(5'h10, b);
        check("R8 irq before abort", irq_done, 0);
        wr(5'h00, 8'h20);                 // code 100
        check("R8 irq after abort", irq_done, 1);
        get_addr(v);
        check("R8 addr kept", v, 16'h4042);
        rd(5'h10, b);
        check("R8 idle after abort", b, 0);
        get_addr(v);
        check("R8 addr still", v, 16'h4042);
    endtask

    task automatic t_ignored();
        int v;
        wr(5'h07, 8'h40);
        setup(16'h4080, 16'd5);
        wr(5'h00, 8'h02);                 // code 000
        wr(5'h00, 8'h1A);                 // code 011
        check("R10 no irq", irq_done, 0);
        get_addr(v);
        check("R10 addr unchanged", v, 16'h4042);
        setup(16'h4090, 16'd0);
        wr(5'h00, 8'h0A);
        check("R10 zero count irq", irq_done, 1);
        get_addr(v);
        check("R10 zero count addr", v, 16'h4090);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) bmem[i] = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_prom_read();
        t_clear();
        t_pkt_write();
        t_prom_write();
        t_pkt_read();
        t_abort();
        t_ignored();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule